// File: doc/BRIEF.md
# Byte-Paced I2C Target Engine with Address-Match Wake

This block is the byte-level engine of an I2C target (slave). It watches the SCL and SDA lines through a synchronizer and reports every byte it takes part in to a controlling agent. After each byte it holds SCL low until the agent writes the control strobe. Received bytes, including the address byte, appear on a data output. Bytes to be sent are loaded through a data write port before the control strobe releases the bus. The agent decides ACK or NACK for every received byte, and it can read the master's acknowledge bit for every byte sent.

Two options reduce the agent's work. With address recognition on, the engine compares the address byte itself and ignores traffic for other targets. Auto-NACK is the low-power mode: once armed, the next address aimed at this target is refused on the bus, a one-cycle wake pulse is raised, and the mode disarms itself. An extended status byte reports bus activity and the direction of the last accepted transaction.

Top module: `i2cs_byte_slave`

## Requirements
- R1: After reset, `status`, `xstatus`, `irq`, `scl_pull` and `sda_pull` are all zero.
- R2: When the eighth bit of a received byte (address or data) has been clocked, the engine sets byte-complete (status bit 0) on the following SCL fall. It holds SCL low until `ctl_we` is pulsed. The received byte is shown on `dr_rdata`.
- R3: `ctl_ack` sampled with `ctl_we` (status bit 4) decides the ninth bit: 1 pulls SDA low (ACK), 0 leaves SDA released (NACK). After a NACK the engine ignores the bus until the next start.
- R4: After a read address has been acknowledged, the byte written through `dr_we` is shifted out MSB first. Each later byte is loaded the same way before the `ctl_we` that releases the stall. The master's ninth bit is stored in status bit 1 (0 = ACK), then byte-complete is set and SCL is held.
- R5: The status byte is laid out as: bit 7 bus error, bit 6 zero, bit 5 stop seen, bit 4 last ACK choice, bit 3 byte was an address, bit 2 transmit direction (R/W bit of the accepted address), bit 1 master's acknowledge bit, bit 0 byte-complete. A `ctl_we` clears bits 7 and 5.
- R6: `irq` is byte-complete, OR stop-seen gated by `stop_irq_en`, OR bus-error gated by `berr_irq_en`.
- R7: With `hw_addr_en` set, an address whose upper seven bits differ from `own_addr` causes no byte-complete, no stall and no ACK. A matching address stalls as in R2.
- R8: A pulse on `anack_set` arms auto-NACK only at the next byte boundary: when the engine is idle or when a byte's last bit is clocked. It does not arm in the middle of a byte.
- R9: While auto-NACK is armed, a matching address is not acknowledged and not stalled. A single-cycle `wake` pulse is raised and auto-NACK disarms. A non-matching address raises no wake.
- R10: `xstatus` bit 7 is bus busy, bit 6 last accepted transaction was a write, bit 5 it was a read, and bit 2 auto-NACK armed. While armed, `xstatus` reads exactly 0x04.
- R11: A start or stop after two or more bits of a byte have been clocked sets bus error. The engine returns to idle with SCL and SDA released.
- R12: Bus busy sets on a start and clears on a stop. The direction bits of `xstatus` follow the LSB of the last accepted address byte (1 = read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Engine enable; low forces idle |
| hw_addr_en | input | 1 | Engine compares the address itself |
| own_addr | input | 7 | This target's 7-bit address |
| stop_irq_en | input | 1 | Interrupt on stop condition |
| berr_irq_en | input | 1 | Interrupt on bus error |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| ctl_we | input | 1 | Control write strobe; releases a stall |
| ctl_ack | input | 1 | ACK choice written with `ctl_we` |
| dr_we | input | 1 | Data register write strobe |
| dr_wdata | input | 8 | Byte to transmit |
| dr_rdata | output | 8 | Last received byte or loaded byte |
| status | output | 8 | Status byte (R5 layout) |
| irq | output | 1 | Interrupt request |
| anack_set | input | 1 | Request auto-NACK |
| anack_clr | input | 1 | Cancel auto-NACK |
| wake | output | 1 | One-cycle pulse on refused matching address |
| xstatus | output | 8 | Extended bus status (R10 layout) |

## Verification
A wrong bit counter or state shows up at the ports within one byte. Byte-complete arrives a clock early or late, or SCL is not held, and the master's next high phase reveals it. It can also show as a bus error flagged on a normal stop. An ACK decision latched wrongly is visible on SDA in the ninth clock of the same byte. An auto-NACK flag that arms too early, or never disarms, changes `xstatus` at once and changes the ACK and `wake` seen on the very next address.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_WAIT,
        ST_STALL,
        ST_SETUP,
        ST_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_TX_WAIT
    } eng_state_t;

    // Status byte; field order is the visible bit order (R5).
    typedef struct packed {
        logic berr;
        logic rsv;
        logic stop_seen;
        logic ack_choice;
        logic is_addr;
        logic tx_dir;
        logic mst_ack;
        logic done;
    } status_t;

    localparam logic [7:0] XS_BUSY  = 8'h80;
    localparam logic [7:0] XS_LWR   = 8'h40;
    localparam logic [7:0] XS_LRD   = 8'h20;
    localparam logic [7:0] XS_ANACK = 8'h04;

    // A start/stop is legal only before the second bit of a byte.
    function automatic logic in_byte(eng_state_t st, logic [3:0] nbits);
        return ((st == ST_RX) || (st == ST_TX)) && (nbits >= 4'd2);
    endfunction

    function automatic logic addr_hit(logic [7:0] b, logic [6:0] own);
        return b[7:1] == own;
    endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic busy
);
    logic [SYNC_DEPTH-1:0] scl_sr, sda_sr;
    logic scl_p, sda_p, scl_s;

    assign scl_s = scl_sr[SYNC_DEPTH-1];
    assign sda_s = sda_sr[SYNC_DEPTH-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
            busy   <= 1'b0;
        end else begin
            scl_sr <= {scl_sr[SYNC_DEPTH-2:0], scl_in};
            sda_sr <= {sda_sr[SYNC_DEPTH-2:0], sda_in};
            scl_p  <= scl_s;
            sda_p  <= sda_s;
            if (start_det)     busy <= 1'b1;
            else if (stop_det) busy <= 1'b0;
        end
    end

    assign scl_rise  =  scl_s & ~scl_p;
    assign scl_fall  = ~scl_s &  scl_p;
    assign start_det =  sda_p & ~sda_s & scl_s & scl_p;
    assign stop_det  = ~sda_p &  sda_s & scl_s & scl_p;

endmodule

// File: rtl/i2cs_byte_engine.sv
module i2cs_byte_engine
    import i2cs_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 7,
    parameter int SETUP_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              hw_addr_en,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              ctl_we,
    input  logic              ctl_ack,
    input  logic              dr_we,
    input  logic [DATA_W-1:0] dr_wdata,
    input  logic              anack_on,
    output logic [DATA_W-1:0] dr_q,
    output status_t           stat,
    output logic              scl_hold,
    output logic              sda_low,
    output logic              boundary,
    output logic              wake,
    output logic              addr_ok
);
    localparam int SW = $clog2(SETUP_CYC + 1);
    localparam logic [3:0] LAST_BIT = 4'(DATA_W - 1);

    eng_state_t        st;
    logic [3:0]        nbits;
    logic [DATA_W-1:0] shreg;
    logic [SW-1:0]     setup_cnt;
    logic              go_tx, byte_end;
    logic [DATA_W-1:0] rx_byte;

    assign rx_byte = {shreg[DATA_W-2:0], sda_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            nbits     <= '0;
            shreg     <= '0;
            dr_q      <= '0;
            stat      <= '0;
            setup_cnt <= '0;
            go_tx     <= 1'b0;
            byte_end  <= 1'b0;
            wake      <= 1'b0;
            addr_ok   <= 1'b0;
        end else begin
            byte_end <= 1'b0;
            wake     <= 1'b0;
            addr_ok  <= 1'b0;
            if (dr_we) dr_q <= dr_wdata;
            if (ctl_we) begin
                stat.berr      <= 1'b0;
                stat.stop_seen <= 1'b0;
            end
            if (!enable) begin
                st        <= ST_IDLE;
                stat.done <= 1'b0;
            end else if (start_det || stop_det) begin
                stat.done <= 1'b0;
                if (stop_det) stat.stop_seen <= 1'b1;
                if (in_byte(st, nbits)) begin
                    stat.berr <= 1'b1;
                    st        <= ST_IDLE;
                end else if (start_det) begin
                    st           <= ST_RX;
                    nbits        <= '0;
                    stat.is_addr <= 1'b1;
                end else begin
                    st <= ST_IDLE;
                end
            end else begin
                case (st)
                    ST_RX: if (scl_rise) begin
                        shreg    <= rx_byte;
                        nbits    <= nbits + 4'd1;
                        if (nbits == LAST_BIT) begin
                            byte_end <= 1'b1;
                            dr_q     <= rx_byte;
                            st       <= ST_RX_WAIT;
                            if (stat.is_addr) begin
                                if (anack_on) begin
                                    st   <= ST_IDLE;
                                    wake <= addr_hit(rx_byte, own_addr);
                                end else if (hw_addr_en && !addr_hit(rx_byte, own_addr)) begin
                                    st <= ST_IDLE;
                                end else begin
                                    stat.tx_dir <= rx_byte[0];
                                    addr_ok     <= addr_hit(rx_byte, own_addr);
                                end
                            end
                        end
                    end
                    ST_RX_WAIT: if (scl_fall) begin
                        stat.done <= 1'b1;
                        st        <= ST_STALL;
                    end
                    ST_STALL: if (ctl_we) begin
                        stat.done       <= 1'b0;
                        stat.ack_choice <= ctl_ack;
                        setup_cnt       <= '0;
                        if (stat.tx_dir && !stat.is_addr) begin
                            if (!stat.mst_ack) begin
                                shreg <= dr_q;
                                nbits <= '0;
                                go_tx <= 1'b1;
                                st    <= ST_SETUP;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else begin
                            go_tx <= 1'b0;
                            st    <= ST_SETUP;
                        end
                    end
                    ST_SETUP: begin
                        setup_cnt <= setup_cnt + 1'b1;
                        if (setup_cnt == SW'(SETUP_CYC - 1))
                            st <= go_tx ? ST_TX : ST_ACK;
                    end
                    ST_ACK: if (scl_fall) begin
                        nbits <= '0;
                        if (!stat.ack_choice) begin
                            st <= ST_IDLE;
                        end else if (stat.is_addr && stat.tx_dir) begin
                            shreg        <= dr_q;
                            stat.is_addr <= 1'b0;
                            st           <= ST_TX;
                        end else begin
                            stat.is_addr <= 1'b0;
                            st           <= ST_RX;
                        end
                    end
                    ST_TX: if (scl_fall) begin
                        shreg <= {shreg[DATA_W-2:0], 1'b0};
                        nbits <= nbits + 4'd1;
                        if (nbits == LAST_BIT) st <= ST_TX_ACK;
                    end
                    ST_TX_ACK: if (scl_rise) begin
                        stat.mst_ack <= sda_s;
                        byte_end     <= 1'b1;
                        st           <= ST_TX_WAIT;
                    end
                    ST_TX_WAIT: if (scl_fall) begin
                        stat.done <= 1'b1;
                        st        <= ST_STALL;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        scl_hold = (st == ST_STALL) || (st == ST_SETUP);
        case (st)
            ST_SETUP: sda_low = go_tx ? ~shreg[DATA_W-1] : stat.ack_choice;
            ST_ACK:   sda_low = stat.ack_choice;
            ST_TX:    sda_low = ~shreg[DATA_W-1];
            default:  sda_low = 1'b0;
        endcase
    end

    assign boundary = (st == ST_IDLE) || byte_end;

    // R2: a pending byte-complete always keeps SCL stretched
    a_r2_done_holds_scl: assert property (@(posedge clk) disable iff (rst)
        stat.done |-> scl_hold);

    // R9: a wake never comes with a stretched clock or an ACK
    a_r9_wake_refuses: assert property (@(posedge clk) disable iff (rst)
        wake |-> (!scl_hold && !sda_low && anack_on));

endmodule

// File: rtl/i2cs_lowpower_ctl.sv
module i2cs_lowpower_ctl
    import i2cs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       anack_set,
    input  logic       anack_clr,
    input  logic       boundary,
    input  logic       wake,
    input  logic       addr_ok,
    input  logic       tx_dir,
    input  logic       busy,
    output logic       anack_on,
    output logic [7:0] xstatus
);
    logic req, last_wr, last_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            req      <= 1'b0;
            anack_on <= 1'b0;
            last_wr  <= 1'b0;
            last_rd  <= 1'b0;
        end else begin
            if (wake || anack_clr) begin
                req      <= 1'b0;
                anack_on <= 1'b0;
            end else begin
                if (anack_set) req <= 1'b1;
                if (req && boundary) anack_on <= 1'b1;
            end
            if (addr_ok) begin
                last_rd <= tx_dir;
                last_wr <= ~tx_dir;
            end
        end
    end

    always_comb begin
        if (anack_on) xstatus = XS_ANACK;
        else xstatus = (busy ? XS_BUSY : 8'h00) | (last_wr ? XS_LWR : 8'h00)
                     | (last_rd ? XS_LRD : 8'h00);
    end

    // R8: arming happens only on a cycle flagged as a byte boundary
    a_r8_arm_on_boundary: assert property (@(posedge clk) disable iff (rst)
        $rose(anack_on) |-> $past(boundary));

    // R9: auto-NACK disarms right after the wake pulse
    a_r9_self_clear: assert property (@(posedge clk) disable iff (rst)
        wake |=> !anack_on);

    // R12: direction flags are never both set
    a_r12_dir_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0({last_wr, last_rd}));

endmodule

// File: rtl/i2cs_byte_slave.sv
module i2cs_byte_slave
    import i2cs_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 7,
    parameter int SYNC_DEPTH = 2,
    parameter int SETUP_CYC  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              hw_addr_en,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              stop_irq_en,
    input  logic              berr_irq_en,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull,
    input  logic              ctl_we,
    input  logic              ctl_ack,
    input  logic              dr_we,
    input  logic [DATA_W-1:0] dr_wdata,
    output logic [DATA_W-1:0] dr_rdata,
    output logic [7:0]        status,
    output logic              irq,
    input  logic              anack_set,
    input  logic              anack_clr,
    output logic              wake,
    output logic [7:0]        xstatus
);
    logic    sda_s, scl_rise, scl_fall, start_det, stop_det, busy;
    logic    anack_on, boundary, addr_ok;
    status_t stat;

    i2cs_line_sync #(.SYNC_DEPTH(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .busy(busy)
    );

    i2cs_byte_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SETUP_CYC(SETUP_CYC)) u_eng (
        .clk(clk), .rst(rst), .enable(enable), .hw_addr_en(hw_addr_en),
        .own_addr(own_addr), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .ctl_we(ctl_we), .ctl_ack(ctl_ack), .dr_we(dr_we), .dr_wdata(dr_wdata),
        .anack_on(anack_on), .dr_q(dr_rdata), .stat(stat),
        .scl_hold(scl_pull), .sda_low(sda_pull), .boundary(boundary),
        .wake(wake), .addr_ok(addr_ok)
    );

    i2cs_lowpower_ctl u_lp (
        .clk(clk), .rst(rst), .anack_set(anack_set), .anack_clr(anack_clr),
        .boundary(boundary), .wake(wake), .addr_ok(addr_ok),
        .tx_dir(stat.tx_dir), .busy(busy), .anack_on(anack_on),
        .xstatus(xstatus)
    );

    assign status = stat;
    assign irq    = stat.done | (stop_irq_en & stat.stop_seen)
                  | (berr_irq_en & stat.berr);

    // R11: a freshly flagged bus error leaves both lines released
    a_r11_berr_release: assert property (@(posedge clk) disable iff (rst)
        $rose(status[7]) |-> (!scl_pull && !sda_pull));

endmodule

// File: tb/i2cs_byte_slave_bench.sv
module i2cs_byte_slave_bench;
    localparam int Q   = 8;
    localparam logic [6:0] OWN = 7'h2A;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1, enable = 1'b0, hw_addr_en = 1'b0;
    logic stop_irq_en = 1'b0, berr_irq_en = 1'b0;
    logic ctl_we = 1'b0, ctl_ack = 1'b0, dr_we = 1'b0;
    logic [7:0] dr_wdata = 8'h00;
    logic anack_set = 1'b0, anack_clr = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic scl_pull, sda_pull, irq, wake;
    logic [7:0] dr_rdata, status, xstatus;
    logic bus_scl, bus_sda;

    assign bus_scl = m_scl & ~scl_pull;
    assign bus_sda = m_sda & ~sda_pull;

    i2cs_byte_slave u_i2cs_byte_slave (
        .clk(clk), .rst(rst), .enable(enable), .hw_addr_en(hw_addr_en),
        .own_addr(OWN), .stop_irq_en(stop_irq_en), .berr_irq_en(berr_irq_en),
        .scl_in(bus_scl), .sda_in(bus_sda), .scl_pull(scl_pull),
        .sda_pull(sda_pull), .ctl_we(ctl_we), .ctl_ack(ctl_ack),
        .dr_we(dr_we), .dr_wdata(dr_wdata), .dr_rdata(dr_rdata),
        .status(status), .irq(irq), .anack_set(anack_set),
        .anack_clr(anack_clr), .wake(wake), .xstatus(xstatus)
    );

    int checks = 0, fails = 0, wakes = 0;

    always @(posedge clk) if (!rst && wake) wakes <= wakes + 1;

    task automatic check(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up();
        m_scl = 1'b1;
        do @(negedge clk); while (!bus_scl);
    endtask

    task automatic m_start();
        m_sda = 1'b1; idle(Q);
        scl_up(); idle(Q);
        m_sda = 1'b0; idle(Q);
        m_scl = 1'b0; idle(Q);
    endtask

    task automatic m_stop();
        m_sda = 1'b0; idle(Q);
        scl_up(); idle(Q);
        m_sda = 1'b1; idle(Q);
    endtask

    task automatic m_wbit(input logic b);
        m_sda = b; idle(Q);
        scl_up(); idle(2 * Q);
        m_scl = 1'b0; idle(Q);
    endtask

    task automatic m_rbit(output logic b);
        m_sda = 1'b1; idle(Q);
        scl_up(); idle(Q);
        b = bus_sda; idle(Q);
        m_scl = 1'b0; idle(Q);
    endtask

    task automatic m_wbyte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) m_wbit(v[i]);
    endtask

    task automatic m_rbyte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) m_rbit(v[i]);
    endtask

    task automatic agent_ctl(input logic a);
        @(negedge clk); ctl_we = 1'b1; ctl_ack = a;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic agent_dr(input logic [7:0] v);
        @(negedge clk); dr_we = 1'b1; dr_wdata = v;
        @(negedge clk); dr_we = 1'b0;
    endtask

    // release SCL and report whether the target keeps it low
    task automatic probe_held(output logic held);
        m_scl = 1'b1; idle(4 * Q);
        held = ~bus_scl;
    endtask

    task automatic t_reset();
        check(status == 8'h00, "R1 status", status, 8'h00);
        check(xstatus == 8'h00, "R1 xstatus", xstatus, 8'h00);
        check({scl_pull, sda_pull, irq} == 3'b000, "R1 pulls/irq",
              {5'b0, scl_pull, sda_pull, irq}, 8'h00);
    endtask

    task automatic t_write();
        logic held, a;
        hw_addr_en = 1'b0; stop_irq_en = 1'b1;
        m_start();
        m_wbyte({OWN, 1'b0});
        probe_held(held);
        check(held, "R2 address stall", {7'b0, held}, 8'h01);
        check(status == 8'h09, "R5 address status", status, 8'h09);
        check(irq, "R6 irq on byte done", {7'b0, irq}, 8'h01);
        check(dr_rdata == {OWN, 1'b0}, "R2 address byte", dr_rdata, {OWN, 1'b0});
        check(xstatus == 8'hC0, "R12 busy+write", xstatus, 8'hC0);
        agent_ctl(1'b1);
        m_rbit(a);
        check(a == 1'b0, "R3 ACK driven", {7'b0, a}, 8'h00);
        m_wbyte(8'hA5);
        probe_held(held);
        check(held && status == 8'h11, "R2 data stall", status, 8'h11);
        check(dr_rdata == 8'hA5, "R2 data byte", dr_rdata, 8'hA5);
        agent_ctl(1'b0);
        m_rbit(a);
        check(a == 1'b1, "R3 NACK released", {7'b0, a}, 8'h01);
        m_stop(); idle(4);
        check(status == 8'h20, "R5 stop seen", status, 8'h20);
        check(irq, "R6 stop irq enabled", {7'b0, irq}, 8'h01);
        stop_irq_en = 1'b0; idle(1);
        check(!irq, "R6 stop irq masked", {7'b0, irq}, 8'h00);
        check(xstatus == 8'h40, "R12 busy cleared, write", xstatus, 8'h40);
        agent_ctl(1'b0);
        check(status == 8'h00, "R5 ctl clears stop", status, 8'h00);
    endtask

    task automatic t_read();
        logic held, a;
        logic [7:0] v;
        m_start();
        m_wbyte({OWN, 1'b1});
        probe_held(held);
        check(held && status == 8'h0D, "R5 read address status", status, 8'h0D);
        agent_dr(8'hC3);
        agent_ctl(1'b1);
        m_rbit(a);
        check(a == 1'b0, "R3 read address ACK", {7'b0, a}, 8'h00);
        m_rbyte(v);
        check(v == 8'hC3, "R4 first byte out", v, 8'hC3);
        m_wbit(1'b0);
        probe_held(held);
        check(held && status == 8'h15, "R4 master ACK stall", status, 8'h15);
        agent_dr(8'h5A);
        agent_ctl(1'b1);
        m_rbyte(v);
        check(v == 8'h5A, "R4 second byte out", v, 8'h5A);
        m_wbit(1'b1);
        probe_held(held);
        check(held && status == 8'h17, "R4 master NACK bit", status, 8'h17);
        agent_ctl(1'b0);
        idle(2);
        check(!scl_pull && !sda_pull, "R4 released after NACK",
              {6'b0, scl_pull, sda_pull}, 8'h00);
        m_stop(); idle(4);
        check(xstatus == 8'h20, "R12 read direction", xstatus, 8'h20);
        agent_ctl(1'b0);
    endtask

    task automatic t_hw_addr();
        logic held, a;
        hw_addr_en = 1'b1;
        m_start();
        m_wbyte(8'h60);
        probe_held(held);
        check(!held && status[0] == 1'b0 && !irq, "R7 foreign address ignored", status, 8'h00);
        m_scl = 1'b0; idle(Q);
        m_rbit(a);
        check(a == 1'b1, "R7 foreign address not ACKed", {7'b0, a}, 8'h01);
        m_stop();
        m_start();
        m_wbyte({OWN, 1'b0});
        probe_held(held);
        check(held && status[0], "R7 own address stalls", status, 8'h09);
        agent_ctl(1'b1);
        m_rbit(a);
        m_stop(); idle(4);
        agent_ctl(1'b0);
        hw_addr_en = 1'b0;
    endtask

    task automatic t_berr();
        logic a;
        berr_irq_en = 1'b1;
        m_start();
        m_wbyte({OWN, 1'b0});
        m_scl = 1'b1; idle(4 * Q);
        agent_ctl(1'b1);
        m_rbit(a);
        m_wbit(1'b1); m_wbit(1'b0); m_wbit(1'b1);
        m_start();
        check(status[7], "R11 bus error flagged", status, 8'h80);
        check(irq, "R11 bus error irq", {7'b0, irq}, 8'h01);
        check(!scl_pull && !sda_pull, "R11 lines released",
              {6'b0, scl_pull, sda_pull}, 8'h00);
        m_stop(); idle(4);
        agent_ctl(1'b0);
        check(status[7] == 1'b0, "R11 error cleared by ctl", status, 8'h00);
        berr_irq_en = 1'b0;
    endtask

    task automatic t_anack();
        logic a;
        hw_addr_en = 1'b1;
        m_start();
        m_wbyte({OWN, 1'b0});
        m_scl = 1'b1; idle(4 * Q);
        agent_ctl(1'b1);
        m_rbit(a);
        m_wbit(1'b0); m_wbit(1'b1); m_wbit(1'b1);
        @(negedge clk); anack_set = 1'b1;
        @(negedge clk); anack_set = 1'b0;
        idle(4);
        check(xstatus[2] == 1'b0, "R8 not armed mid-byte", xstatus, 8'hC0);
        m_wbit(1'b0); m_wbit(1'b0); m_wbit(1'b1); m_wbit(1'b1); m_wbit(1'b0);
        check(xstatus == 8'h04, "R8 armed at boundary", xstatus, 8'h04);
        m_scl = 1'b1; idle(4 * Q);
        agent_ctl(1'b1);
        m_rbit(a);
        m_stop(); idle(4);
        check(xstatus == 8'h04, "R10 others masked while armed", xstatus, 8'h04);
        m_start();
        m_wbyte(8'h60);
        m_rbit(a);
        check(a == 1'b1 && wakes == 0, "R9 foreign address no wake", 8'(wakes), 8'h00);
        m_stop();
        m_start();
        m_wbyte({OWN, 1'b1});
        m_rbit(a);
        check(a == 1'b1, "R9 own address NACKed", {7'b0, a}, 8'h01);
        check(wakes == 1, "R9 single wake pulse", 8'(wakes), 8'h01);
        check(xstatus[2] == 1'b0, "R9 disarmed after wake", xstatus, 8'hC0);
        m_stop(); idle(4);
        check(xstatus == 8'h40, "R10 direction kept", xstatus, 8'h40);
    endtask

    logic done = 1'b0;

    initial begin
        idle(4);
        t_reset();
        rst = 1'b0; enable = 1'b1;
        idle(4);
        t_write();
        t_read();
        t_hw_addr();
        t_berr();
        t_anack();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule